// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a cache and keeps track of load-linked reservations for a small set of cache lines. Each hardware context is named by a CPU number and a thread number. The monitor does not see addresses or data. The surrounding cache resolves each access to a line index and hands that index to the monitor together with the requesting context.

A request port accepts at most one operation per cycle: a load-linked, a plain store or a conditional store. A separate invalidation port, used on eviction or on a coherence invalidate, can name a line in the same cycle. Each line can hold a reservation for every context at the same time. Any write to a line removes the reservations of all contexts on that line, not only the writer's.

For every store, one registered response comes back on the following cycle. The response carries a pass/fail flag for a conditional store and a write-enable that tells the cache whether the store may update the line.

Top module: `llsc_reservation_monitor`

## Requirements
- R1: Reset leaves no reservation on any line and holds `resp_valid` low. A conditional store issued before any load-linked fails.
- R2: A load-linked (`req_kind` = 2'd0) records a reservation for the context {`req_cpu`, `req_thread`} on `req_line`. A following conditional store (`req_kind` = 2'd2) from that same context to that line passes, with `resp_sc_ok` = 1 and `resp_wr_en` = 1.
- R3: A conditional store fails (`resp_sc_ok` = 0, `resp_wr_en` = 0) unless both its CPU number and its thread number match a reservation held on the line.
- R4: Repeating a load-linked from the same context to the same line is harmless. One later conditional store passes, and a second conditional store right after it fails.
- R5: Any conditional store to a line removes every reservation on that line, whether the store passes or fails.
- R6: A plain store (`req_kind` = 2'd1) removes every reservation on its line, including those of other contexts. It always reports `resp_wr_en` = 1 and `resp_sc_ok` = 0.
- R7: An invalidation (`inv_valid` with `inv_line`) removes every reservation on that line.
- R8: Stores and invalidations leave the reservations on all other lines unchanged.
- R9: If a conditional store and an invalidation name the same line in the same cycle, the invalidation takes precedence and the store fails. An invalidation of a different line in that cycle does not affect the outcome.
- R10: `resp_valid` is high in exactly the cycle after each accepted store of either kind. In every other cycle, `resp_valid`, `resp_sc_ok` and `resp_wr_en` are all low.
- R11: `resp_wr_en` is low for a store only when that store is a failed conditional store. `resp_sc_ok` is never high without `resp_wr_en`.
- R12: If a load-linked and an invalidation name the same line in the same cycle, no reservation is recorded.
- R13: The reserved request code 2'd3 produces no response and changes no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 0 load-linked, 1 plain store, 2 conditional store, 3 reserved |
| req_line | input | clog2(LINES) | Line index of the request |
| req_cpu | input | clog2(CPUS) | CPU number of the requester |
| req_thread | input | clog2(THREADS) | Thread number of the requester |
| inv_valid | input | 1 | Invalidate a line this cycle |
| inv_line | input | clog2(LINES) | Line index to invalidate |
| resp_valid | output | 1 | Response for the store of the previous cycle |
| resp_sc_ok | output | 1 | Conditional store passed (1) or failed (0) |
| resp_wr_en | output | 1 | The store may write the line |

## Verification
The bench builds the monitor with 4 lines, 4 CPUs and 2 threads. That gives eight contexts, so a reservation can be tested against requesters that differ only in CPU number or only in thread number. It also reaches the highest line index and the highest context {3,1} as boundary cases. With four lines, the bench can invalidate or store to one line while watching reservations on a neighbouring line. It can also collide an invalidation with a load-linked or a conditional store, both on the same line and on different lines.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        K_LOAD_LINK  = 2'd0,
        K_STORE      = 2'd1,
        K_STORE_COND = 2'd2,
        K_RESERVED   = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic valid;
        logic sc_ok;
        logic wr_en;
    } resp_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int ctx_total(input int cpus, input int threads);
        return cpus * threads;
    endfunction

endpackage

// File: rtl/llsc_ctx_decode.sv
module llsc_ctx_decode
    import llsc_pkg::*;
#(
    parameter int CPUS    = 4,
    parameter int THREADS = 2,
    parameter int CPU_W   = idx_width(CPUS),
    parameter int THR_W   = idx_width(THREADS),
    parameter int CTX     = ctx_total(CPUS, THREADS)
) (
    input  logic [CPU_W-1:0] cpu,
    input  logic [THR_W-1:0] thread,
    output logic [CTX-1:0]   ctx_mask
);

    // One bit per context, laid out as cpu*THREADS + thread.
    always_comb begin
        for (int i = 0; i < CTX; i++) begin
            ctx_mask[i] = (cpu == CPU_W'(i / THREADS)) &&
                          (thread == THR_W'(i % THREADS));
        end
    end

endmodule

// File: rtl/llsc_line_bank.sv
module llsc_line_bank #(
    parameter int CTX = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           set_en,
    input  logic [CTX-1:0] set_mask,
    input  logic           clr,
    output logic [CTX-1:0] resv
);

    always_ff @(posedge clk) begin
        if (rst) begin
            resv <= '0;
        end else if (clr) begin
            resv <= '0;
        end else if (set_en) begin
            resv <= resv | set_mask;
        end
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> resv == '0);

    // R5
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> resv == '0);

    // R2
    set_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr) |=> ((resv & $past(set_mask)) == $past(set_mask)));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr) |=> $stable(resv));

endmodule

// File: rtl/llsc_resp_reg.sv
module llsc_resp_reg
    import llsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic is_store,
    input  logic is_cond,
    input  logic pass,
    output resp_t resp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp.valid <= is_store;
            resp.sc_ok <= is_store && is_cond && pass;
            resp.wr_en <= is_store && (!is_cond || pass);
        end
    end

    // R11
    ok_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
        resp.sc_ok |-> (resp.wr_en && resp.valid));

    // R6
    plain_store_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (is_store && !is_cond) |=> (resp.wr_en && !resp.sc_ok));

endmodule

// File: rtl/llsc_reservation_monitor.sv
module llsc_reservation_monitor
    import llsc_pkg::*;
#(
    parameter int LINES   = 8,
    parameter int CPUS    = 4,
    parameter int THREADS = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic [1:0]                     req_kind,
    input  logic [idx_width(LINES)-1:0]    req_line,
    input  logic [idx_width(CPUS)-1:0]     req_cpu,
    input  logic [idx_width(THREADS)-1:0]  req_thread,
    input  logic                           inv_valid,
    input  logic [idx_width(LINES)-1:0]    inv_line,
    output logic                           resp_valid,
    output logic                           resp_sc_ok,
    output logic                           resp_wr_en
);

    localparam int LINE_W = idx_width(LINES);
    localparam int CPU_W  = idx_width(CPUS);
    localparam int THR_W  = idx_width(THREADS);
    localparam int CTX    = ctx_total(CPUS, THREADS);

    req_kind_e kind;
    logic      is_ll, is_store, is_cond;
    logic      inv_same_line;
    logic [CTX-1:0]   ctx_mask;
    logic [LINES-1:0] line_hit;
    logic             pass;
    resp_t            resp;

    assign kind          = req_kind_e'(req_kind);
    assign is_ll         = req_valid && (kind == K_LOAD_LINK);
    assign is_cond       = req_valid && (kind == K_STORE_COND);
    assign is_store      = req_valid && ((kind == K_STORE) || (kind == K_STORE_COND));
    assign inv_same_line = inv_valid && (inv_line == req_line);

    llsc_ctx_decode #(
        .CPUS    (CPUS),
        .THREADS (THREADS),
        .CPU_W   (CPU_W),
        .THR_W   (THR_W),
        .CTX     (CTX)
    ) ctx_dec_i (
        .cpu      (req_cpu),
        .thread   (req_thread),
        .ctx_mask (ctx_mask)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic           sel_req;
        logic           sel_inv;
        logic           set_en;
        logic           clr;
        logic [CTX-1:0] resv;

        assign sel_req = req_valid && (req_line == LINE_W'(g));
        assign sel_inv = inv_valid && (inv_line == LINE_W'(g));
        // An invalidate on the same line overrides a load-linked.
        assign set_en  = sel_req && is_ll && !sel_inv;
        assign clr     = sel_inv || (sel_req && is_store);

        llsc_line_bank #(
            .CTX (CTX)
        ) bank_i (
            .clk      (clk),
            .rst      (rst),
            .set_en   (set_en),
            .set_mask (ctx_mask),
            .clr      (clr),
            .resv     (resv)
        );

        assign line_hit[g] = sel_req && |(resv & ctx_mask);
    end

    // An invalidate that collides with the store kills the reservation first.
    assign pass = (|line_hit) && !inv_same_line;

    llsc_resp_reg resp_i (
        .clk      (clk),
        .rst      (rst),
        .is_store (is_store),
        .is_cond  (is_cond),
        .pass     (pass),
        .resp     (resp)
    );

    assign resp_valid = resp.valid;
    assign resp_sc_ok = resp.sc_ok;
    assign resp_wr_en = resp.wr_en;

    // R10
    resp_follows_store_chk: assert property (@(posedge clk) disable iff (rst)
        is_store |=> resp_valid);

    // R10
    no_resp_otherwise_chk: assert property (@(posedge clk) disable iff (rst)
        !is_store |=> (!resp_valid && !resp_sc_ok && !resp_wr_en));

    // R9
    inv_beats_sc_chk: assert property (@(posedge clk) disable iff (rst)
        (is_cond && inv_same_line) |=> (!resp_sc_ok && !resp_wr_en));

    // R13
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == K_RESERVED) |=> !resp_valid);

endmodule

// File: tb/llsc_reservation_monitor_tb_top.sv
module llsc_reservation_monitor_tb_top;

    localparam int LINES   = 4;
    localparam int CPUS    = 4;
    localparam int THREADS = 2;
    localparam int CTX     = CPUS * THREADS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [1:0] req_line = '0;
    logic [1:0] req_cpu = '0;
    logic [0:0] req_thread = '0;
    logic       inv_valid = 1'b0;
    logic [1:0] inv_line = '0;
    logic       resp_valid, resp_sc_ok, resp_wr_en;

    typedef struct {
        logic  v;
        logic  ok;
        logic  we;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [CTX-1:0] model [LINES];

    always #4 clk = ~clk;

    llsc_reservation_monitor #(
        .LINES   (LINES),
        .CPUS    (CPUS),
        .THREADS (THREADS)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_line   (req_line),
        .req_cpu    (req_cpu),
        .req_thread (req_thread),
        .inv_valid  (inv_valid),
        .inv_line   (inv_line),
        .resp_valid (resp_valid),
        .resp_sc_ok (resp_sc_ok),
        .resp_wr_en (resp_wr_en)
    );

    task automatic issue(input bit rv, input logic [1:0] k, input int ln,
                         input int c, input int t, input bit iv, input int il,
                         input string tag);
        exp_t e;
        int   cx;
        bit   st, sc, ok;
        @(negedge clk);
        req_valid  = rv;
        req_kind   = k;
        req_line   = 2'(ln);
        req_cpu    = 2'(c);
        req_thread = 1'(t);
        inv_valid  = iv;
        inv_line   = 2'(il);
        cx = c * THREADS + t;
        st = rv && (k == 2'd1 || k == 2'd2);
        sc = rv && (k == 2'd2);
        ok = sc && model[ln][cx] && !(iv && il == ln);
        e.v   = st;
        e.ok  = ok;
        e.we  = st && (!sc || ok);
        e.tag = st ? tag : "R10";
        q.push_back(e);
        if (iv) model[il] = '0;
        if (rv && k == 2'd0 && !(iv && il == ln)) model[ln][cx] = 1'b1;
        if (st) model[ln] = '0;
    endtask

    task automatic ll(input int ln, input int c, input int t);
        issue(1, 2'd0, ln, c, t, 0, 0, "R2");
    endtask

    task automatic sc(input int ln, input int c, input int t, input string tag);
        issue(1, 2'd2, ln, c, t, 0, 0, tag);
    endtask

    task automatic idle();
        issue(0, 2'd0, 0, 0, 0, 0, 0, "R10");
    endtask

    // Monitor: compare each registered response against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (resp_valid !== e.v || resp_sc_ok !== e.ok || resp_wr_en !== e.we) begin
                    errors++;
                    $display("FAIL %s: got v/ok/we=%b%b%b expected %b%b%b",
                             e.tag, resp_valid, resp_sc_ok, resp_wr_en, e.v, e.ok, e.we);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (resp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got resp_valid=%b expected 0", resp_valid);
        end

        // R1: conditional store before any load-linked fails
        sc(0, 0, 0, "R1");
        // R2: matching context passes
        ll(1, 1, 0); sc(1, 1, 0, "R2");
        // R3: CPU differs, then thread differs
        ll(2, 2, 1); sc(2, 3, 1, "R3");
        ll(2, 2, 1); sc(2, 2, 0, "R3");
        // R4: duplicate load-linked, top line and top context
        ll(3, 3, 1); ll(3, 3, 1); sc(3, 3, 1, "R4"); sc(3, 3, 1, "R4");
        // R5: a failed conditional store clears other contexts
        ll(0, 0, 0); ll(0, 1, 1); sc(0, 2, 0, "R5"); sc(0, 0, 0, "R5");
        // R6: plain store clears everyone and always writes
        ll(1, 0, 1); ll(1, 2, 0);
        issue(1, 2'd1, 1, 3, 0, 0, 0, "R6");
        sc(1, 0, 1, "R6");
        // R7: invalidation clears the line
        ll(2, 1, 1); issue(0, 2'd0, 0, 0, 0, 1, 2, "R7"); sc(2, 1, 1, "R7");
        // R8: activity on other lines leaves line 0 intact
        ll(0, 0, 0); ll(3, 0, 0);
        issue(1, 2'd1, 3, 0, 0, 0, 0, "R8");
        issue(0, 2'd0, 0, 0, 0, 1, 1, "R8");
        sc(0, 0, 0, "R8");
        // R9: same-line invalidate beats the conditional store
        ll(1, 1, 0); issue(1, 2'd2, 1, 1, 0, 1, 1, "R9");
        // R9: invalidate of another line does not matter
        ll(2, 0, 0); issue(1, 2'd2, 2, 0, 0, 1, 3, "R9");
        // R12: load-linked colliding with invalidate records nothing
        issue(1, 2'd0, 0, 2, 1, 1, 0, "R12"); sc(0, 2, 1, "R12");
        // R13: reserved code ignored
        ll(1, 0, 0); issue(1, 2'd3, 1, 0, 0, 0, 0, "R13"); sc(1, 0, 0, "R13");
        // R11: plain store with no reservation still writes
        issue(1, 2'd1, 2, 1, 1, 0, 0, "R11");
        idle(); idle();

        @(posedge clk);
        #3;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule